// File: doc/BRIEF.md
# Inverse-Time Heart-Rate Meter

This block turns a digital pulse train, one rising edge per heartbeat, into a heart rate in beats per minute. The rate is measured from each single interval between two consecutive beats, with no averaging. Each beat reports the interval that has just ended, and the next measurement starts at the same time.

No division is performed. A down-counting rate register starts at 255 on each beat. A prescaler steps it down by one each time it expires. The prescaler reload for each step is taken from a table of constants, computed at elaboration, whose spacing grows as the rate falls. As a result the register holds roughly sixty seconds divided by the elapsed time. The parameter `TICKS_PER_MIN` is the number of clock cycles in one minute. The result goes to an 8-bit latch that holds steady between beats, so a display decoder can read it at leisure. A one-cycle strobe marks each update. A flag marks intervals that are too short or too long to map into the 30 to 255 range.

Top module: `hr_rate_meter`

## Requirements
- R1: The pulse input passes through two synchronizing flops, and each rising edge becomes one beat. The first beat after reset only starts a measurement and does not assert `valid_o`.
- R2: Every later beat asserts `valid_o` for exactly one cycle. It asserts three clock edges after the input rises, and `rate_o`/`oor_o` update in that same cycle.
- R3: Let D be the number of clock cycles between two rising edges, e = D-1 and T = TICKS_PER_MIN. When floor(T/256) <= e < floor(T/30), `rate_o` is the smallest N in 30..254 with floor(T/(N+1)) <= e, or 255 if no such N exists. In this case `oor_o` is 0.
- R4: When e < floor(T/256) (faster than 255 bpm), `rate_o` is 255 and `oor_o` is 1.
- R5: When e >= floor(T/30) (slower than 30 bpm), `rate_o` is 0 and `oor_o` is 1. Internally the count holds at 30.
- R6: `rate_o` and `oor_o` change only in the cycle in which `valid_o` is high. Otherwise they hold their value until the next beat.
- R7: While `rst_ni` is low, `rate_o`, `valid_o` and `oor_o` are 0, and the next beat after release counts as a first beat.
- R8: When a beat falls in the same cycle as a scheduled count step, the beat wins. The value from before the step is reported and the new measurement restarts from 255.
- R9: The internal rate count never drops below 30, and it moves by at most one per cycle while tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; T cycles per minute |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Asynchronous beat pulse; rising edge marks a beat |
| rate_o | output | 8 | Latched rate in beats per minute, unsigned binary |
| valid_o | output | 1 | One-cycle strobe when a new rate is latched |
| oor_o | output | 1 | Latched out-of-range flag for the current rate |

## Verification
A beat can arrive in exactly the cycle in which the prescaler expires and the rate count would step. The same can happen at the step that ends the fast region or the one that enters the slow region. The bench provokes these collisions with pairs of intervals one cycle apart, placed on each side of a step point: floor(T/121), floor(T/256) and floor(T/30). The two members of each pair must report values one step apart, or differ in the range flag. Each following measurement must again be correct, which shows that the beat's reload took priority over the step.

// File: rtl/hr_pkg.sv
package hr_pkg;
  localparam int MIN_RATE = 30;
  localparam int MAX_RATE = 255;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SEEK  = 2'd1,
    PH_TRACK = 2'd2,
    PH_UNDER = 2'd3
  } phase_e;

  // cycles between reaching rate n and reaching n-1, minus one for reload
  function automatic int step_reload(input int n, input int ticks);
    if (n < MIN_RATE || n > MAX_RATE) return 0;
    return ticks / n - ticks / (n + 1) - 1;
  endfunction
endpackage

// File: rtl/hr_pulse_sync.sv
module hr_pulse_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic beat_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pulse_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign beat_o = s2_q & ~s3_q;

  // R1
  beat_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |=> !beat_o);
endmodule

// File: rtl/hr_spacing_rom.sv
module hr_spacing_rom #(
  parameter int TICKS_PER_MIN = 120000,
  parameter int PRE_W         = 9
) (
  input  logic [7:0]       idx_i,
  output logic [PRE_W-1:0] reload_o
);
  localparam int DEPTH = hr_pkg::MAX_RATE + 1;

  logic [PRE_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = PRE_W'(hr_pkg::step_reload(g, TICKS_PER_MIN));
  end

  assign reload_o = tbl[idx_i];
endmodule

// File: rtl/hr_inv_counter.sv
module hr_inv_counter #(
  parameter int TICKS_PER_MIN = 120000,
  parameter int PRE_W         = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           beat_i,
  output logic [7:0]     count_o,
  output hr_pkg::phase_e phase_o
);
  import hr_pkg::*;

  localparam logic [7:0]       TOP_CNT = 8'(MAX_RATE);
  localparam logic [7:0]       BOT_CNT = 8'(MIN_RATE);
  // first expiry lands at floor(T/256): entry into the reportable range
  localparam logic [PRE_W-1:0] FIRST_LOAD = PRE_W'(TICKS_PER_MIN / 256 - 1);

  phase_e           phase_q;
  logic [7:0]       count_q;
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       rom_idx;
  logic [PRE_W-1:0] reload;
  logic             expire;

  assign expire  = (pre_q == '0);
  assign rom_idx = (phase_q == PH_SEEK) ? TOP_CNT : count_q - 8'd1;

  hr_spacing_rom #(
    .TICKS_PER_MIN(TICKS_PER_MIN),
    .PRE_W        (PRE_W)
  ) u_rom (
    .idx_i   (rom_idx),
    .reload_o(reload)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      count_q <= '0;
      pre_q   <= '0;
    end else if (beat_i) begin
      phase_q <= PH_SEEK;
      count_q <= TOP_CNT;
      pre_q   <= FIRST_LOAD;
    end else begin
      unique case (phase_q)
        PH_SEEK: begin
          if (expire) begin
            phase_q <= PH_TRACK;
            pre_q   <= reload;
          end else begin
            pre_q <= pre_q - 1'b1;
          end
        end
        PH_TRACK: begin
          if (expire) begin
            if (count_q == BOT_CNT) begin
              phase_q <= PH_UNDER;
            end else begin
              count_q <= count_q - 8'd1;
              pre_q   <= reload;
            end
          end else begin
            pre_q <= pre_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign count_o = count_q;
  assign phase_o = phase_q;

  // R9
  count_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (count_q >= BOT_CNT));
  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TRACK && !beat_i) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) - 8'd1));
  // R8
  beat_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |=> (phase_q == PH_SEEK && count_q == TOP_CNT));
endmodule

// File: rtl/hr_out_latch.sv
module hr_out_latch (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           beat_i,
  input  hr_pkg::phase_e phase_i,
  input  logic [7:0]     count_i,
  output logic [7:0]     rate_o,
  output logic           valid_o,
  output logic           oor_o
);
  import hr_pkg::*;

  logic [7:0] rate_d;
  logic       oor_d;

  always_comb begin
    rate_d = count_i;
    oor_d  = 1'b0;
    unique case (phase_i)
      PH_SEEK:  begin rate_d = 8'(MAX_RATE); oor_d = 1'b1; end
      PH_UNDER: begin rate_d = 8'd0;         oor_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o  <= '0;
      oor_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (beat_i && phase_i != PH_IDLE) begin
        rate_o  <= rate_d;
        oor_o   <= oor_d;
        valid_o <= 1'b1;
      end
    end
  end

  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o || ($stable(rate_o) && $stable(oor_o))));
  // R4
  oor_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> (rate_o == 8'd0 || rate_o == 8'd255));
endmodule

// File: rtl/hr_rate_meter.sv
module hr_rate_meter #(
  parameter int TICKS_PER_MIN = 120000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_i,
  output logic [7:0] rate_o,
  output logic       valid_o,
  output logic       oor_o
);
  localparam int PRE_W = $clog2(TICKS_PER_MIN / 256 + 1);

  logic           beat;
  logic [7:0]     count;
  hr_pkg::phase_e phase;

  hr_pulse_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .beat_o (beat)
  );

  hr_inv_counter #(
    .TICKS_PER_MIN(TICKS_PER_MIN),
    .PRE_W        (PRE_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat),
    .count_o(count),
    .phase_o(phase)
  );

  hr_out_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat),
    .phase_i(phase),
    .count_i(count),
    .rate_o (rate_o),
    .valid_o(valid_o),
    .oor_o  (oor_o)
  );

  // R7
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (rate_o == 8'd0 && !valid_o && !oor_o));
endmodule

// File: tb/hr_rate_meter_bench.sv
module hr_rate_meter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 120000;
  localparam int NVEC       = 14;
  localparam int WATCHDOG   = 200000;

  // interval in cycles, expected range flag
  localparam int GAP_TBL [NVEC] = '{1000, 992, 991, 2000, 469, 468, 100,
                                    3000, 4000, 4001, 4500, 600, 3871, 3870};
  localparam bit OOR_TBL [NVEC] = '{0, 0, 0, 0, 0, 1, 1,
                                    0, 0, 1, 1, 0, 0, 0};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pulse_i = 1'b0;
  logic [7:0] rate_o;
  logic       valid_o;
  logic       oor_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] s_rate;
  logic       s_valid;
  logic       s_oor;

  hr_rate_meter #(.TICKS_PER_MIN(T)) u_hr_rate_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .rate_o (rate_o),
    .valid_o(valid_o),
    .oor_o  (oor_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [8:0] model(input int d);
    int e;
    e = d - 1;
    if (e < T / 256) return {1'b1, 8'd255};
    if (e >= T / 30) return {1'b1, 8'd0};
    for (int n = 30; n <= 254; n++)
      if (T / (n + 1) <= e) return {1'b0, 8'(n)};
    return {1'b0, 8'd255};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // rise now, sample strobe 3 edges later, hold until gap cycles elapsed
  task automatic send_beat(input int gap);
    pulse_i = 1'b1;
    @(negedge clk_i) pulse_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    s_rate = rate_o; s_valid = valid_o; s_oor = oor_o;
    repeat (gap - 4) @(negedge clk_i);
    check("R6 rate held", rate_o, s_rate);
    check("R6 flag held", oor_o, s_oor);
    @(negedge clk_i);
  endtask

  task automatic judge(input int gap, input string tag);
    logic [8:0] m;
    m = model(gap);
    check({tag, " valid"}, s_valid, 1);
    check({tag, " rate"}, s_rate, m[7:0]);
    check({tag, " flag"}, s_oor, m[8]);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R7 reset state
    check("R7 rate", rate_o, 0);
    check("R7 valid", valid_o, 0);
    check("R7 flag", oor_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 first beat arms only
    send_beat(GAP_TBL[0]);
    check("R1 first valid", s_valid, 0);

    for (int i = 1; i <= NVEC; i++) begin
      send_beat(i < NVEC ? GAP_TBL[i] : 700);
      // R3 R4 R5 R8 by interval class; R2 strobe
      judge(GAP_TBL[i-1], OOR_TBL[i-1] ? "R4/R5 R2" : "R3 R8 R2");
      check("R4/R5 table flag", s_oor, OOR_TBL[i-1]);
    end

    // R8: boundary pair exact values
    check("R8 pre-step", model(991) & 9'h0ff, 121);
    check("R8 post-step", model(992) & 9'h0ff, 120);

    // R7 mid-run reset
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i);
    check("R7 mid rate", rate_o, 0);
    check("R7 mid flag", oor_o, 0);
    check("R7 mid valid", valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    send_beat(700);
    check("R1 after reset valid", s_valid, 0);
    send_beat(500);
    judge(700, "R3 R2 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule